// File: doc/BRIEF.md
# DMA Interrupt Aggregation Register Bank

This block collects the interrupt events of an eight-channel DMA engine and turns them into a single interrupt line. Every channel can raise five kinds of event, each a one-cycle pulse on its own input: transfer done, block done, source transaction done, destination transaction done and error. For each kind the bank keeps a latched raw vector, an enable mask and a status vector, which is the raw vector gated by the mask. A five-bit summary shows which kinds have any status bit set.

Software uses a simple word-addressed write port to program masks, acknowledge events, switch channels on and off and enable the engine as a whole. A combinational read port returns every view. Mask and channel-enable writes carry a per-bit write-enable byte above the data byte. Software can therefore change one channel's bit without reading the register first.

Top module: `dma_irq_bank`

## Requirements
- R1: An event pulse on bit i of class c sets raw bit i of that class at the next rising clock edge, whatever the mask holds. The raw vector of class c reads at word address c (classes 0 to 4: transfer, block, source, destination, error). Bit i of class c arrives on ev_in[c*8+i].
- R2: The status vector of class c reads at address 8+c and equals raw AND mask of that class.
- R3: A write to address 24+c clears every raw bit of class c whose data bit is one and leaves the other raw bits unchanged. Reading those addresses returns zero.
- R4: If an event on a bit arrives in the same cycle as a clear of that bit, the raw bit is set after the edge.
- R5: The summary at address 29 has bit c set exactly when some status bit of class c is set. Bits 15:5 read zero.
- R6: A write to the mask of class c at address 16+c updates only the mask bits whose write enable (wr_data bit 8+i for data bit i) is one. Mask bit one enables the interrupt.
- R7: The channel-enable register at address 30 follows the same write-enable rule as R6 and is visible on ch_en_o. Changing it leaves the raw bits as they were.
- R8: Bit 0 of the configuration word at address 31 is the global enable, visible on dma_en_o. irq is high exactly when the global enable is one and any status bit of any class is set.
- R9: After reset all raw, mask, channel-enable and global-enable state is zero. Every readable address reads zero and irq is low.
- R10: Writes to raw, status, summary or unused addresses change no state. Raw bits change only through events and clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | 40 | Event pulses, class c channel i on bit c*8+i |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 5 | Word address of the write |
| wr_data | input | 16 | Write data; bits 15:8 are lane enables for mask and channel-enable writes |
| rd_addr | input | 5 | Word address of the read |
| rd_data | output | 16 | Combinational read data |
| irq | output | 1 | Aggregated interrupt |
| ch_en_o | output | 8 | Channel-enable register |
| dma_en_o | output | 1 | Global engine enable |

## Verification
The assertions assume that reset is held high from time zero until after the first clock edge. They also assume that the event and write inputs are stable around each rising edge. Events may be any pattern of bits, on any cycle, including bits that are masked, bits on disabled channels and bits in the same cycle as a clear. The stimulus drives every input only on falling edges and asserts reset from the start. Its random addresses cover the whole 5-bit space, including the unused and read-only words, so the bench's write-ignore checks see real traffic.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int unsigned NUM_CLS = 5;
    localparam int unsigned ADDR_W  = 5;

    typedef enum logic [2:0] {
        CLS_XFER  = 3'd0,
        CLS_BLOCK = 3'd1,
        CLS_SRC   = 3'd2,
        CLS_DST   = 3'd3,
        CLS_ERR   = 3'd4
    } ev_class_e;

    typedef enum logic [2:0] {
        GRP_RAW,
        GRP_STAT,
        GRP_MASK,
        GRP_CLR,
        GRP_SUMM,
        GRP_CHEN,
        GRP_CFG,
        GRP_NONE
    } reg_grp_e;

    typedef struct packed {
        reg_grp_e   grp;
        logic [2:0] cls;
    } reg_sel_t;

    localparam logic [2:0] SUMM_SLOT = 3'd5;
    localparam logic [2:0] CHEN_SLOT = 3'd6;
    localparam logic [2:0] CFG_SLOT  = 3'd7;

    function automatic reg_sel_t decode_addr(logic [ADDR_W-1:0] a);
        reg_sel_t s;
        logic     in_cls;
        s.cls  = a[2:0];
        in_cls = (32'(a[2:0]) < NUM_CLS);
        s.grp  = GRP_NONE;
        unique case (a[4:3])
            2'd0: s.grp = in_cls ? GRP_RAW  : GRP_NONE;
            2'd1: s.grp = in_cls ? GRP_STAT : GRP_NONE;
            2'd2: s.grp = in_cls ? GRP_MASK : GRP_NONE;
            default: begin
                if (in_cls)                 s.grp = GRP_CLR;
                else if (a[2:0] == SUMM_SLOT) s.grp = GRP_SUMM;
                else if (a[2:0] == CHEN_SLOT) s.grp = GRP_CHEN;
                else                          s.grp = GRP_CFG;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dma_irq_wrdec.sv
module dma_irq_wrdec
    import dma_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [2*NUM_CH-1:0]               wr_data,
    output logic [NUM_CLS-1:0][NUM_CH-1:0]    clr_bits,
    output logic [NUM_CLS-1:0]                mask_we,
    output logic                              chen_we,
    output logic                              cfg_we,
    output logic [NUM_CH-1:0]                 lane_en,
    output logic [NUM_CH-1:0]                 lane_val
);
    reg_sel_t sel;

    always_comb sel = decode_addr(wr_addr);

    assign lane_en  = wr_data[2*NUM_CH-1:NUM_CH];
    assign lane_val = wr_data[NUM_CH-1:0];
    assign chen_we  = wr_en && (sel.grp == GRP_CHEN);
    assign cfg_we   = wr_en && (sel.grp == GRP_CFG);

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls_dec
        logic hit;
        assign hit         = (sel.cls == 3'(c));
        assign mask_we[c]  = wr_en && (sel.grp == GRP_MASK) && hit;
        assign clr_bits[c] = (wr_en && (sel.grp == GRP_CLR) && hit) ? lane_val : '0;
    end

endmodule

// File: rtl/dma_irq_class.sv
module dma_irq_class #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ev,
    input  logic [NUM_CH-1:0] clr,
    input  logic              mask_we,
    input  logic [NUM_CH-1:0] lane_en,
    input  logic [NUM_CH-1:0] lane_val,
    output logic [NUM_CH-1:0] raw,
    output logic [NUM_CH-1:0] mask,
    output logic [NUM_CH-1:0] status,
    output logic              any
);
    logic [NUM_CH-1:0] raw_nxt;
    logic [NUM_CH-1:0] mask_nxt;

    // event wins over a same-cycle acknowledge
    always_comb raw_nxt  = (raw & ~clr) | ev;
    always_comb mask_nxt = (mask & ~lane_en) | (lane_val & lane_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= raw_nxt;
            if (mask_we) mask <= mask_nxt;
        end
    end

    assign status = raw & mask;
    assign any    = |status;

    p_event_sets_raw_r1: assert property (@(posedge clk) disable iff (rst)
        (ev != '0) |=> ((raw & $past(ev)) == $past(ev)));

    p_clear_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (clr != '0) |=> ((raw & $past(clr & ~ev)) == '0));

    p_event_beats_clear_r4: assert property (@(posedge clk) disable iff (rst)
        ((clr & ev) != '0) |=> ((raw & $past(clr & ev)) == $past(clr & ev)));

    p_raw_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        ((clr == '0) && (ev == '0)) |=> $stable(raw));

    p_mask_lanes_r6: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (((mask ^ $past(mask)) & ~$past(lane_en)) == '0));

    p_mask_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask));

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chen_we,
    input  logic              cfg_we,
    input  logic [NUM_CH-1:0] lane_en,
    input  logic [NUM_CH-1:0] lane_val,
    output logic [NUM_CH-1:0] chen,
    output logic              dma_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            chen   <= '0;
            dma_en <= 1'b0;
        end else begin
            if (chen_we) chen   <= (chen & ~lane_en) | (lane_val & lane_en);
            if (cfg_we)  dma_en <= lane_val[0];
        end
    end

    p_chen_lanes_r7: assert property (@(posedge clk) disable iff (rst)
        chen_we |=> (((chen ^ $past(chen)) & ~$past(lane_en)) == '0));

    p_chen_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !chen_we |=> $stable(chen));

    p_enable_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(dma_en));

endmodule

// File: rtl/dma_irq_rdmux.sv
module dma_irq_rdmux
    import dma_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic [ADDR_W-1:0]              rd_addr,
    input  logic [NUM_CLS-1:0][NUM_CH-1:0] raw,
    input  logic [NUM_CLS-1:0][NUM_CH-1:0] mask,
    input  logic [NUM_CLS-1:0][NUM_CH-1:0] status,
    input  logic [NUM_CLS-1:0]             summary,
    input  logic [NUM_CH-1:0]              chen,
    input  logic                           dma_en,
    output logic [2*NUM_CH-1:0]            rd_data
);
    localparam int unsigned DATA_W = 2 * NUM_CH;

    reg_sel_t              sel;
    logic [NUM_CLS-1:0][NUM_CH-1:0] pick_raw;
    logic [NUM_CLS-1:0][NUM_CH-1:0] pick_stat;
    logic [NUM_CLS-1:0][NUM_CH-1:0] pick_mask;
    logic [NUM_CH-1:0]     raw_sel;
    logic [NUM_CH-1:0]     stat_sel;
    logic [NUM_CH-1:0]     mask_sel;

    always_comb sel = decode_addr(rd_addr);

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_pick
        logic hit;
        assign hit          = (sel.cls == 3'(c));
        assign pick_raw[c]  = hit ? raw[c]    : '0;
        assign pick_stat[c] = hit ? status[c] : '0;
        assign pick_mask[c] = hit ? mask[c]   : '0;
    end

    always_comb begin
        raw_sel  = '0;
        stat_sel = '0;
        mask_sel = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            raw_sel  |= pick_raw[c];
            stat_sel |= pick_stat[c];
            mask_sel |= pick_mask[c];
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (sel.grp)
            GRP_RAW:  rd_data = DATA_W'(raw_sel);
            GRP_STAT: rd_data = DATA_W'(stat_sel);
            GRP_MASK: rd_data = DATA_W'(mask_sel);
            GRP_SUMM: rd_data = DATA_W'(summary);
            GRP_CHEN: rd_data = DATA_W'(chen);
            GRP_CFG:  rd_data = DATA_W'(dma_en);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
    import dma_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_CLS*NUM_CH-1:0]   ev_in,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [2*NUM_CH-1:0]         wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [2*NUM_CH-1:0]         rd_data,
    output logic                        irq,
    output logic [NUM_CH-1:0]           ch_en_o,
    output logic                        dma_en_o
);
    logic [NUM_CLS-1:0][NUM_CH-1:0] clr_bits;
    logic [NUM_CLS-1:0][NUM_CH-1:0] raw_a;
    logic [NUM_CLS-1:0][NUM_CH-1:0] mask_a;
    logic [NUM_CLS-1:0][NUM_CH-1:0] stat_a;
    logic [NUM_CLS-1:0]             mask_we;
    logic [NUM_CLS-1:0]             summary;
    logic                           chen_we;
    logic                           cfg_we;
    logic [NUM_CH-1:0]              lane_en;
    logic [NUM_CH-1:0]              lane_val;

    dma_irq_wrdec #(.NUM_CH(NUM_CH)) u_wrdec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .clr_bits (clr_bits),
        .mask_we  (mask_we),
        .chen_we  (chen_we),
        .cfg_we   (cfg_we),
        .lane_en  (lane_en),
        .lane_val (lane_val)
    );

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_class
        dma_irq_class #(.NUM_CH(NUM_CH)) u_class (
            .clk      (clk),
            .rst      (rst),
            .ev       (ev_in[c*NUM_CH +: NUM_CH]),
            .clr      (clr_bits[c]),
            .mask_we  (mask_we[c]),
            .lane_en  (lane_en),
            .lane_val (lane_val),
            .raw      (raw_a[c]),
            .mask     (mask_a[c]),
            .status   (stat_a[c]),
            .any      (summary[c])
        );
    end

    dma_irq_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .chen_we  (chen_we),
        .cfg_we   (cfg_we),
        .lane_en  (lane_en),
        .lane_val (lane_val),
        .chen     (ch_en_o),
        .dma_en   (dma_en_o)
    );

    dma_irq_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
        .rd_addr  (rd_addr),
        .raw      (raw_a),
        .mask     (mask_a),
        .status   (stat_a),
        .summary  (summary),
        .chen     (ch_en_o),
        .dma_en   (dma_en_o),
        .rd_data  (rd_data)
    );

    assign irq = dma_en_o && (summary != '0);

    p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
        !dma_en_o |-> !irq);

    p_irq_needs_status_r2: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((raw_a & mask_a) != '0));

    p_chen_keeps_raw_r7: assert property (@(posedge clk) disable iff (rst)
        (chen_we && (clr_bits == '0) && (ev_in == '0)) |=> $stable(raw_a));

endmodule

// File: tb/dma_irq_bank_tb_top.sv
module dma_irq_bank_tb_top;

    localparam int NCH = 8;
    localparam int NCL = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [39:0] ev_in = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq;
    logic [7:0]  ch_en_o;
    logic        dma_en_o;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    bit [7:0] m_raw  [NCL];
    bit [7:0] m_mask [NCL];
    bit [7:0] m_chen;
    bit       m_en;
    string    tag_force = "";

    always #10 clk = ~clk;

    dma_irq_bank dut_i (
        .clk      (clk),
        .rst      (rst),
        .ev_in    (ev_in),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq      (irq),
        .ch_en_o  (ch_en_o),
        .dma_en_o (dma_en_o)
    );

    function automatic bit [15:0] exp_read(bit [4:0] a);
        int k = int'(a[2:0]);
        bit [15:0] v = '0;
        case (a[4:3])
            2'd0: if (k < NCL) v = 16'(m_raw[k]);
            2'd1: if (k < NCL) v = 16'(m_raw[k] & m_mask[k]);
            2'd2: if (k < NCL) v = 16'(m_mask[k]);
            default: begin
                if (k == 5) begin
                    for (int c = 0; c < NCL; c++) v[c] = |(m_raw[c] & m_mask[c]);
                end else if (k == 6) v = 16'(m_chen);
                else if (k == 7) v = 16'(m_en);
            end
        endcase
        return v;
    endfunction

    function automatic string tag_of(bit [4:0] a);
        int k = int'(a[2:0]);
        if (tag_force != "") return tag_force;
        case (a[4:3])
            2'd0: return (k < NCL) ? "R1" : "R10";
            2'd1: return (k < NCL) ? "R2" : "R10";
            2'd2: return (k < NCL) ? "R6" : "R10";
            default: return (k < NCL) ? "R3" : (k == 5) ? "R5" : (k == 6) ? "R7" : "R8";
        endcase
    endfunction

    function automatic bit exp_irq();
        bit any = 1'b0;
        for (int c = 0; c < NCL; c++) any |= |(m_raw[c] & m_mask[c]);
        return m_en && any;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic compare_all();
        bit [15:0] e = exp_read(rd_addr);
        check(rd_data == e, tag_of(rd_addr), $sformatf("rd_data@%0d", rd_addr), rd_data, e);
        check(irq == exp_irq(), (tag_force != "") ? tag_force : "R8", "irq", irq, exp_irq());
        check(ch_en_o == m_chen, (tag_force != "") ? tag_force : "R7", "ch_en_o", ch_en_o, m_chen);
        check(dma_en_o == m_en, (tag_force != "") ? tag_force : "R8", "dma_en_o", dma_en_o, m_en);
    endtask

    task automatic model_step(bit [39:0] ev, bit we, bit [4:0] a, bit [15:0] d);
        int k = int'(a[2:0]);
        bit [7:0] en_l = d[15:8];
        bit [7:0] val  = d[7:0];
        for (int c = 0; c < NCL; c++) begin
            bit [7:0] clr = (we && a[4:3] == 2'd3 && k == c) ? val : 8'h00;
            m_raw[c] = (m_raw[c] & ~clr) | ev[c*8 +: 8];
        end
        if (we && a[4:3] == 2'd2 && k < NCL)
            m_mask[k] = (m_mask[k] & ~en_l) | (val & en_l);
        if (we && a == 5'd30) m_chen = (m_chen & ~en_l) | (val & en_l);
        if (we && a == 5'd31) m_en = d[0];
    endtask

    task automatic cyc(bit [39:0] ev, bit we, bit [4:0] wa, bit [15:0] wd, bit [4:0] ra);
        @(negedge clk);
        compare_all();
        ev_in   = ev;
        wr_en   = we;
        wr_addr = wa;
        wr_data = wd;
        rd_addr = ra;
        @(posedge clk);
        model_step(ev, we, wa, wd);
    endtask

    task automatic idle_read(bit [4:0] ra);
        cyc('0, 1'b0, 5'd0, 16'h0000, ra);
    endtask

    initial begin
        #4_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCL; c++) begin
            m_raw[c]  = '0;
            m_mask[c] = '0;
        end
        m_chen = '0;
        m_en   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9: reset state, sweep every address
        tag_force = "R9";
        for (int a = 0; a < 32; a++) idle_read(5'(a));
        tag_force = "";

        // R8: global enable on; R6: mask class 0 lanes 3:0 to 0101
        cyc('0, 1'b1, 5'd31, 16'h0001, 5'd31);
        cyc('0, 1'b1, 5'd16, 16'h0F05, 5'd16);
        // R1: events on class 0 bits 0,1 (bit 1 masked)
        cyc(40'h3, 1'b0, 5'd0, 16'h0, 5'd0);
        idle_read(5'd8);
        idle_read(5'd29);
        // R6: change only lane 1
        cyc('0, 1'b1, 5'd16, 16'h0202, 5'd16);
        idle_read(5'd16);
        // R4: event and clear on the same bit
        tag_force = "R4";
        cyc(40'h2, 1'b1, 5'd24, 16'h0002, 5'd0);
        idle_read(5'd0);
        tag_force = "";
        // R3: clear bits 1:0, then read clear address
        cyc('0, 1'b1, 5'd24, 16'h0003, 5'd24);
        idle_read(5'd0);
        // R10: writes to read-only and unused addresses
        cyc(40'h01_0000_0000, 1'b0, 5'd0, 16'h0, 5'd4);
        tag_force = "R10";
        cyc('0, 1'b1, 5'd4, 16'hFFFF, 5'd4);
        cyc('0, 1'b1, 5'd9, 16'hFFFF, 5'd4);
        cyc('0, 1'b1, 5'd29, 16'hFFFF, 5'd4);
        cyc('0, 1'b1, 5'd7, 16'hFFFF, 5'd4);
        idle_read(5'd29);
        tag_force = "";
        // R7: channel enables with lanes; raw of class 4 must survive
        cyc('0, 1'b1, 5'd30, 16'hFFA5, 5'd30);
        cyc('0, 1'b1, 5'd30, 16'h0100, 5'd30);
        cyc('0, 1'b1, 5'd20, 16'h0101, 5'd30);
        tag_force = "R7";
        idle_read(5'd4);
        tag_force = "";
        idle_read(5'd12);
        // R8: global disable masks irq while status stays
        cyc('0, 1'b1, 5'd31, 16'h0000, 5'd12);
        idle_read(5'd29);
        cyc('0, 1'b1, 5'd31, 16'hFFFF, 5'd31);
        idle_read(5'd31);

        // mixed random traffic, checked every clock against the model
        for (int n = 0; n < 1500; n++) begin
            bit [39:0] ev = {8'($urandom & $urandom & $urandom),
                             32'($urandom & $urandom & $urandom)};
            bit we = ($urandom % 3) != 0;
            bit [4:0] wa = 5'($urandom);
            bit [15:0] wd = 16'($urandom);
            cyc(ev, we, wa, wd, 5'($urandom));
        end
        @(negedge clk);
        compare_all();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule